// File: doc/BRIEF.md
# Register Write-Protection Lock Sequencer

This block decides whether a peripheral's configuration registers may be written. Software unlocks the registers by writing a four-byte key, one byte per write, to a status byte. Once the key is complete, writes to the protected registers are passed through for a short window measured in seconds ticks. When the window ends, the registers relock by themselves. Writing the lock code while unlocked closes the window at once.

After power-on reset the registers start unlocked. They relock after a longer startup window, so boot code can configure the peripheral before it unlocks anything. A status bit reports whether protection is active, and software can poll it and retry the key. Any write to the protected registers while they are locked is dropped, and a sticky error flag is set.

Top module: `wp_lock_guard`

## Requirements
- R1: After reset, `locked_o` is 0, `drop_err_o` is 0, and the relock countdown is loaded with `POR_SECS` ticks.
- R2: Four consecutive key writes of 0x00, 0x40, 0xC0 and 0x80, in that order, clear `locked_o` in the cycle after the 0x80 write.
- R3: A key write that does not match the next expected byte sends the tracker back to its first step. A 0x00 write always counts as the first key byte.
- R4: While unlocked, a key write of 0x80 that does not complete the key sets `locked_o` in the next cycle.
- R5: After the key completes, `locked_o` rises in the cycle after the `UNLOCK_SECS`-th seconds tick (default 2).
- R6: After reset, `locked_o` rises in the cycle after the `POR_SECS`-th seconds tick (default 15).
- R7: `reg_we_o` equals `reg_we_i` in the same cycle while `locked_o` is 0, and is 0 while `locked_o` is 1.
- R8: A `reg_we_i` pulse while locked sets `drop_err_o` in the next cycle, and the flag stays set until reset.
- R9: Completing the key while already unlocked reloads the countdown to `UNLOCK_SECS` ticks. A completed key takes priority over the lock meaning of its final 0x80.
- R10: While locked, seconds ticks and a lone 0x80 key write leave `locked_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| key_we_i | input | 1 | Byte write strobe to the status/key byte |
| key_data_i | input | 8 | Byte written to the status/key byte |
| reg_we_i | input | 1 | Write request to a protected register |
| reg_we_o | output | 1 | Gated write enable to the protected registers |
| locked_o | output | 1 | Protection-enabled status bit |
| drop_err_o | output | 1 | Sticky flag: a write was dropped while locked |

## Verification
The key path is tried with the exact sequence, with a sequence broken by a foreign byte, and with a sequence restarted by an early 0x00. Together these separate an order-checking tracker from one that only counts matching bytes. A lone 0x80 is sent both while unlocked and while locked, which shows whether the lock code and the final key byte are kept apart. Tick bursts of different lengths after reset and after each unlock locate the relock edge exactly. A random stream weighted toward the key bytes then mixes all of these cases against a cycle model.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam int KEY_LEN = 4;
  localparam logic [7:0] LOCK_CODE = 8'h80;

  function automatic logic [7:0] key_byte(input int unsigned idx);
    case (idx)
      0: key_byte = 8'h00;
      1: key_byte = 8'h40;
      2: key_byte = 8'hC0;
      default: key_byte = 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/wp_key_tracker.sv
module wp_key_tracker
  import wp_lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output logic       done_o,
  output logic       lock_code_o
);
  localparam int SW = $clog2(KEY_LEN);

  logic [SW-1:0] step_q, step_d;
  logic          match;

  assign match       = data_i == key_byte(32'(step_q));
  assign done_o      = we_i && match && (step_q == SW'(KEY_LEN - 1));
  assign lock_code_o = we_i && !done_o && (data_i == LOCK_CODE);

  always_comb begin
    step_d = step_q;
    if (we_i) begin
      if (done_o)                     step_d = '0;
      else if (data_i == key_byte(0)) step_d = SW'(1);
      else if (match)                 step_d = step_q + SW'(1);
      else                            step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && data_i == 8'h00 |=> step_q == SW'(1));
  // R3
  mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && data_i != 8'h00 && !match |=> step_q == '0);
endmodule

// File: rtl/wp_relock_timer.sv
module wp_relock_timer #(
  parameter int UNLOCK_SECS = 2,
  parameter int POR_SECS    = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic unlock_i,
  input  logic lock_i,
  output logic locked_o
);
  localparam int MAXS = (POR_SECS > UNLOCK_SECS) ? POR_SECS : UNLOCK_SECS;
  localparam int CW   = $clog2(MAXS + 1);

  logic [CW-1:0] cnt_q;
  logic          locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cnt_q    <= CW'(POR_SECS);
    end else if (unlock_i) begin
      locked_q <= 1'b0;
      cnt_q    <= CW'(UNLOCK_SECS);
    end else if (lock_i && !locked_q) begin
      locked_q <= 1'b1;
      cnt_q    <= '0;
    end else if (tick_i && !locked_q) begin
      if (cnt_q <= CW'(1)) begin
        locked_q <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign locked_o = locked_q;

  // R2
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i |=> !locked_o);
  // R4
  lock_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !unlock_i |=> locked_o);
  // R10
  hold_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !unlock_i |=> locked_o);
  // R5
  live_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> cnt_q != '0);
endmodule

// File: rtl/wp_lock_guard.sv
module wp_lock_guard #(
  parameter int UNLOCK_SECS = 2,
  parameter int POR_SECS    = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_tick_i,
  input  logic       key_we_i,
  input  logic [7:0] key_data_i,
  input  logic       reg_we_i,
  output logic       reg_we_o,
  output logic       locked_o,
  output logic       drop_err_o
);
  logic key_done, lock_code, locked;
  logic err_q;

  wp_key_tracker u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (key_we_i),
    .data_i     (key_data_i),
    .done_o     (key_done),
    .lock_code_o(lock_code)
  );

  wp_relock_timer #(
    .UNLOCK_SECS(UNLOCK_SECS),
    .POR_SECS   (POR_SECS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sec_tick_i),
    .unlock_i(key_done),
    .lock_i  (lock_code),
    .locked_o(locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_q <= 1'b0;
    else if (reg_we_i && locked) err_q <= 1'b1;
  end

  assign reg_we_o   = reg_we_i && !locked;
  assign locked_o   = locked;
  assign drop_err_o = err_q;

  // R8
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && locked_o |=> drop_err_o);
  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_err_o |=> drop_err_o);
  // R7
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_we_i);
endmodule

// File: tb/wp_lock_guard_test.sv
module wp_lock_guard_test;
  localparam int US = 2;
  localparam int PS = 15;

  logic clk = 0, rst_n = 0;
  logic tick = 0, kwe = 0, rwe = 0;
  logic [7:0] kd = 0;
  logic reg_we, locked, err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  int m_step, m_cnt;
  bit m_locked, m_err;

  always #10 clk = ~clk;

  wp_lock_guard #(.UNLOCK_SECS(US), .POR_SECS(PS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .key_we_i(kwe),
    .key_data_i(kd), .reg_we_i(rwe), .reg_we_o(reg_we),
    .locked_o(locked), .drop_err_o(err));

  function automatic logic [7:0] kb(int i);
    case (i) 0: return 8'h00; 1: return 8'h40; 2: return 8'hC0; default: return 8'h80; endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(bit t, bit w, logic [7:0] d, bit r);
    bit dn, lc;
    dn = w && d == kb(m_step) && m_step == 3;
    lc = w && !dn && d == 8'h80;
    if (r && m_locked) m_err = 1;
    if (w) begin
      if (dn) m_step = 0;
      else if (d == 8'h00) m_step = 1;
      else if (d == kb(m_step)) m_step++;
      else m_step = 0;
    end
    if (dn) begin m_locked = 0; m_cnt = US; end
    else if (lc && !m_locked) begin m_locked = 1; m_cnt = 0; end
    else if (t && !m_locked) begin
      if (m_cnt <= 1) begin m_locked = 1; m_cnt = 0; end else m_cnt--;
    end
  endtask

  // one clock cycle: drive, check gate, clock, check state
  task automatic cyc(bit t, bit w, logic [7:0] d, bit r);
    @(negedge clk);
    tick = t; kwe = w; kd = d; rwe = r;
    #1 chk("R7 gate", reg_we, r && !m_locked);
    @(posedge clk);
    model_update(t, w, d, r);
    #5;
    chk("R2/R4/R5/R6 lock state", locked, m_locked);
    chk("R8 drop flag", err, m_err);
  endtask

  task automatic key(logic [7:0] d); cyc(0, 1, d, 0); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) cyc(1, 0, 8'h00, 0); endtask
  task automatic full_key(); for (int i = 0; i < 4; i++) key(kb(i)); endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_step = 0; m_cnt = PS; m_locked = 0; m_err = 0;
    #45 rst_n = 1;
    #10;
    chk("R1 reset lock", locked, 0);
    chk("R1 reset err", err, 0);
    cyc(0, 0, 0, 1);                 // R7 pass-through while unlocked
    chk("R7 write passed", err, 0);
    // R6: startup window
    ticks(PS - 1);
    chk("R6 before window end", locked, 0);
    ticks(1);
    chk("R6 locked at window end", locked, 1);
    // R10: ticks and lone lock code while locked
    ticks(3); key(8'h80);
    chk("R10 stays locked", locked, 1);
    // R7/R8: dropped write
    cyc(0, 0, 0, 1);
    chk("R8 err set", err, 1);
    // R3: broken key
    key(8'h00); key(8'h40); key(8'h11); key(8'hC0); key(8'h80);
    chk("R3 broken key stays locked", locked, 1);
    // R3: restart with 0x00 mid-key
    key(8'h00); key(8'h40); key(8'h00); key(8'h40); key(8'hC0); key(8'h80);
    chk("R3 restart then unlock", locked, 0);
    // R5: auto relock after US ticks
    ticks(US - 1);
    chk("R5 still open", locked, 0);
    ticks(1);
    chk("R5 relocked", locked, 1);
    // R9: reload on second key while unlocked
    full_key(); ticks(US - 1); full_key(); ticks(US - 1);
    chk("R9 reload kept open", locked, 0);
    ticks(1);
    chk("R9 relock after reload", locked, 1);
    // R4: lone lock code while unlocked
    full_key(); key(8'h80);
    chk("R4 lock code", locked, 1);
    chk("R8 still sticky", err, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int p;
      logic [7:0] d;
      p = $urandom_range(0, 9);
      d = (p < 8) ? kb(p % 4) : 8'($urandom);
      cyc($urandom_range(0, 15) == 0, $urandom_range(0, 2) != 0, d, $urandom_range(0, 7) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule